// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire SMBus

This block is the configuration port of a clock generator. A system controller reaches it over a two-wire SMBus-compatible bus, on which the block answers as a slave at 7-bit address 0x69. It holds a small bank of control bytes. Those bytes decide which CPU and SRC differential output pairs are enabled, and how each pair behaves when the chip is powered down or stopped. Two strap bits sampled at power-up are also visible as read-only bits.

The bus pins are oversampled by the system clock through a synchronizer. SDA is driven as an open-drain output: when `sda_oe` is high, the pad pulls the line low. The first byte after the address is a command byte. When command bit 7 is 1, the access is a single-byte access at the offset held in bits 6:0. A command of 0x00 selects a block access: a block write carries a byte count, and a block read returns one. Block accesses always run upward from offset 0. The full register contents are also presented to the rest of the chip as a flat vector.

The controller has these states: `ST_IDLE`, `ST_ADDR`, `ST_CMD`, `ST_COUNT`, `ST_WDATA`, `ST_ACK`, `ST_RDATA`, `ST_RACK` and `ST_IGNORE`. Its transitions are as follows:
- A stop in any state goes to `ST_IDLE`.
- A start in any state goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ACK` when the address matches, otherwise to `ST_IGNORE`.
- `ST_CMD` goes to `ST_ACK` for a legal command, otherwise to `ST_IGNORE`.
- `ST_COUNT` always goes to `ST_ACK`.
- `ST_WDATA` goes to `ST_ACK` while bytes are still owed, otherwise to `ST_IGNORE`.
- `ST_ACK` goes to the successor it stored (`ST_CMD`, `ST_COUNT`, `ST_WDATA` or `ST_RDATA`) when SCL falls at the end of the acknowledge bit.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` when the master acknowledges, and to `ST_IGNORE` when it does not.

Top module: `clkctl_smbus_slave`

## Requirements
- R1: After reset, register 1 holds 0x7F, register 2 and registers 3..6 hold 0x00, and `sda_oe` is low.
- R2: The address byte 0xD2 (write) is acknowledged. An address byte whose upper seven bits differ from 0x69 is not acknowledged, and the rest of that transaction acknowledges nothing and changes no register.
- R3: A command with bit 7 = 1 is a byte access at offset bits 6:0. A command with bit 7 = 0 must be exactly 0x00 (block access); any other such command is not acknowledged.
- R4: A byte write (0xD2, command, data) acknowledges all three bytes and stores the data at the offset. A second data byte in the same byte write is not acknowledged and is not stored.
- R5: A block write (0xD2, 0x00, count N, data) stores its data bytes at offsets 0, 1, 2 and so on, in order. Data bytes after the N-th are not acknowledged and are not stored.
- R6: A byte read (0xD2, command, repeated start, 0xD3) returns the register at the offset, MSB first. The read address is acknowledged.
- R7: A block read (0xD2, 0x00, repeated start, 0xD3) first returns the count 7, then registers 0 upward, for as long as the master acknowledges. A master NACK ends the transfer.
- R8: Register 0 reads as {6'b0, strap_sel[1], strap_sel[0]} and ignores writes. Register 1 bits 5:3 stay 1, and register 2 bits 2:0 stay 0, whatever is written.
- R9: Offsets 7 and above read 0x00. Writes to them are acknowledged but discarded.
- R10: The control outputs map to register bits as follows:
  - `src_stop_en` is register 1 bit 7, `src_oe` is bit 6, and `cpu_oe[2:0]` is bits 2:0.
  - `src_pd_tri` is register 2 bit 7, `src_stop_tri` is bit 6, and `cpu_pd_tri[2:0]` is bits 5:3.
- R11: A stop ends any transaction and forgets its command. A start in mid-byte restarts address reception. A read address with no command earlier in the same transaction is not acknowledged.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_sel | input | 2 | Power-up frequency strap bits, shown read-only in register 0 |
| regs_flat | output | NUM_REGS*8 | All register bytes; register k sits at bits 8k+7:8k |
| cpu_oe | output | 3 | Enable for CPU pairs 2..0 |
| src_oe | output | 1 | Enable for the SRC pair |
| src_stop_en | output | 1 | SRC pair may be stopped by the stop request |
| src_pd_tri | output | 1 | SRC pair floats in power-down |
| src_stop_tri | output | 1 | SRC pair floats when stopped |
| cpu_pd_tri | output | 3 | CPU pairs 2..0 float in power-down |

## Verification
The bench aims at the following corner cases:
- Bytes that follow a refused address. A slave that kept decoding them would acknowledge them and corrupt the registers.
- A byte write that carries an extra byte, and a block write that sends more bytes than its count. A design without the byte budget would overwrite the next register.
- Reads without a command, and starts that arrive in mid-byte. A design that keeps a stale command or a partial shift count would answer the wrong offset or mistime its acknowledge.
- Masked bits and offsets past the end. A design that wrote them would show changed reserved bits, or non-zero bytes read at high offsets.

// File: rtl/clkctl_smb_pkg.sv
package clkctl_smb_pkg;

    localparam int CPU_PAIRS = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } smb_state_e;

    // Reset value of each register byte
    function automatic logic [7:0] reg_reset_val(input int idx);
        if (idx == 1) return 8'h7F;
        return 8'h00;
    endfunction

    // Bits that a bus write may change
    function automatic logic [7:0] reg_write_mask(input int idx);
        if (idx == 0) return 8'h00;
        if (idx == 1) return 8'hC7;
        if (idx == 2) return 8'hF8;
        return 8'hFF;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[TOP];
            sda_q    <= sda_pipe[TOP];
        end
    end

    assign scl_s     = scl_pipe[TOP];
    assign sda_s     = sda_pipe[TOP];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import clkctl_smb_pkg::*;
#(
    parameter int NUM_REGS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [6:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [6:0]            rd_addr,
    input  logic [1:0]            strap_sel,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    logic [NUM_REGS-1:0][7:0] reg_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_strap
            assign reg_q[g] = {6'b000000, strap_sel};
        end else begin : g_rw
            localparam logic [7:0] RST = reg_reset_val(g);
            localparam logic [7:0] MSK = reg_write_mask(g);
            logic [7:0] stored;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stored <= RST;
                else if (wr_en && wr_addr == 7'(g))
                    stored <= (stored & ~MSK) | (wr_data & MSK);
            end
            assign reg_q[g] = stored;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == 7'(i)) rd_data = reg_q[i];
    end

    assign regs_flat = reg_q;

endmodule

// File: rtl/smb_protocol_fsm.sv
module smb_protocol_fsm
    import clkctl_smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_addr,
    output logic       wr_en,
    output logic [6:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output smb_state_e state_o
);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    smb_state_e state, ack_next;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [6:0] ptr;
    logic [6:0] cmd_off;
    logic       block_mode;
    logic       cmd_seen;
    logic       send_count;
    logic       master_ack;
    logic [7:0] wr_left;

    logic       rx_phase;
    logic       byte_done;
    logic       load_tx;
    logic [7:0] tx_byte;

    assign rx_phase  = (state == ST_ADDR) || (state == ST_CMD) ||
                       (state == ST_COUNT) || (state == ST_WDATA);
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign load_tx   = scl_fall && (((state == ST_ACK) && (ack_next == ST_RDATA)) ||
                                    ((state == ST_RACK) && master_ack));
    assign tx_byte   = send_count ? COUNT_BYTE : rd_data;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ack_next   <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            ptr        <= '0;
            cmd_off    <= '0;
            block_mode <= 1'b0;
            cmd_seen   <= 1'b0;
            send_count <= 1'b0;
            master_ack <= 1'b0;
            wr_left    <= '0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            cmd_seen <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else begin
            if (rx_phase && scl_rise) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 4'd1;
            end
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_ADDR: if (byte_done) begin
                    bit_cnt <= '0;
                    if (shreg[7:1] == DEV_ADDR && (!shreg[0] || cmd_seen)) begin
                        state      <= ST_ACK;
                        ack_next   <= shreg[0] ? ST_RDATA : ST_CMD;
                        send_count <= shreg[0] & block_mode;
                        if (shreg[0]) ptr <= cmd_off;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_CMD: if (byte_done) begin
                    bit_cnt <= '0;
                    if (shreg[7] || shreg == 8'h00) begin
                        state      <= ST_ACK;
                        ack_next   <= shreg[7] ? ST_WDATA : ST_COUNT;
                        block_mode <= ~shreg[7];
                        cmd_off    <= shreg[6:0];
                        ptr        <= shreg[6:0];
                        cmd_seen   <= 1'b1;
                        wr_left    <= shreg[7] ? 8'd1 : 8'd0;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_COUNT: if (byte_done) begin
                    bit_cnt  <= '0;
                    wr_left  <= shreg;
                    state    <= ST_ACK;
                    ack_next <= ST_WDATA;
                end
                ST_WDATA: if (byte_done) begin
                    bit_cnt <= '0;
                    if (wr_left != 8'd0) begin
                        wr_left  <= wr_left - 8'd1;
                        ptr      <= ptr + 7'd1;
                        state    <= ST_ACK;
                        ack_next <= ST_WDATA;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    state   <= ack_next;
                    bit_cnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_rise)
                        bit_cnt <= bit_cnt + 4'd1;
                    else if (scl_fall) begin
                        if (bit_cnt == 4'd8) state <= ST_RACK;
                        else                 shreg <= {shreg[6:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise)
                        master_ack <= ~sda_s;
                    else if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= master_ack ? ST_RDATA : ST_IGNORE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (load_tx) begin
                shreg <= tx_byte;
                if (send_count) send_count <= 1'b0;
                else            ptr        <= ptr + 7'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ACK:   sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~shreg[7];
            default:  sda_oe = 1'b0;
        endcase
        wr_en   = (state == ST_WDATA) && byte_done && (wr_left != 8'd0) &&
                  !stop_det && !start_det;
        wr_addr = ptr;
        wr_data = shreg;
        rd_addr = ptr;
        state_o = state;
    end

endmodule

// File: rtl/clkctl_smbus_slave.sv
module clkctl_smbus_slave
    import clkctl_smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [1:0]            strap_sel,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic [CPU_PAIRS-1:0]  cpu_oe,
    output logic                  src_oe,
    output logic                  src_stop_en,
    output logic                  src_pd_tri,
    output logic                  src_stop_tri,
    output logic [CPU_PAIRS-1:0]  cpu_pd_tri
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_data, wr_data;
    logic [6:0] rd_addr, wr_addr;
    logic       wr_en;
    smb_state_e fsm_state;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_protocol_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .state_o   (fsm_state)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .strap_sel (strap_sel),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    // Control fields of registers 1 and 2
    assign cpu_oe       = regs_flat[8 +: CPU_PAIRS];
    assign src_oe       = regs_flat[14];
    assign src_stop_en  = regs_flat[15];
    assign cpu_pd_tri   = regs_flat[19 +: CPU_PAIRS];
    assign src_stop_tri = regs_flat[22];
    assign src_pd_tri   = regs_flat[23];

endmodule

// File: rtl/clkctl_smb_checker.sv
module clkctl_smb_checker
    import clkctl_smb_pkg::*;
#(
    parameter int NUM_REGS = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic                  scl_fall,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input smb_state_e            fsm_state
);
    // R1: values seen on the first cycle out of reset
    p_reset_values_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs_flat[15:8] == 8'h7F && regs_flat[23:16] == 8'h00 && !sda_oe));

    // R4: writable bytes change only at the end of an SCL low edge
    p_write_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_fall |=> $stable(regs_flat[NUM_REGS*8-1:8]));

    // R8: fixed bits never move
    p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        regs_flat[7:2] == 6'd0 && regs_flat[13:11] == 3'b111 && regs_flat[18:16] == 3'b000);

    // R11: an idle slave leaves SDA released
    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_IDLE |-> !sda_oe);

    // R12: no SDA movement while SCL has been high for a while
    p_oe_steady_scl_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3) && $past(scl_i, 4))
        |-> $stable(sda_oe));

endmodule

bind clkctl_smbus_slave clkctl_smb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .regs_flat (regs_flat),
    .fsm_state (fsm_state)
);

// File: tb/test_clkctl_smbus_slave.sv
`timescale 1ns/1ps
module test_clkctl_smbus_slave;
    localparam int NREG = 7;
    localparam int Q    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic [1:0]      strap = 2'b10;
    logic            sda_oe;
    logic            sda_line;
    logic [NREG*8-1:0] regs_flat;
    logic [2:0]      cpu_oe, cpu_pd_tri;
    logic            src_oe, src_stop_en, src_pd_tri, src_stop_tri;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    clkctl_smbus_slave i_clkctl_smbus_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe       (sda_oe),
        .strap_sel    (strap),
        .regs_flat    (regs_flat),
        .cpu_oe       (cpu_oe),
        .src_oe       (src_oe),
        .src_stop_en  (src_stop_en),
        .src_pd_tri   (src_pd_tri),
        .src_stop_tri (src_stop_tri),
        .cpu_pd_tri   (cpu_pd_tri)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [7:0] exp_reg [NREG];
    logic [7:0] xfer [16];
    logic [15:0] acks;

    // R12 monitor: SDA drive must not move during a long SCL high
    int   hi_cnt = 0;
    int   viol = 0;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (scl_m) hi_cnt++; else hi_cnt = 0;
        if (rst_n && hi_cnt >= 5 && sda_oe !== oe_prev) viol++;
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int i);
        if (i == 0) return 8'h00;
        if (i == 1) return 8'hC7;
        if (i == 2) return 8'hF8;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] model_rd(input int off);
        if (off == 0) return {6'd0, strap};
        if (off < NREG) return exp_reg[off];
        return 8'h00;
    endfunction

    task automatic model_wr(input int off, input logic [7:0] d);
        if (off > 0 && off < NREG)
            exp_reg[off] = (exp_reg[off] & ~mask_of(off)) | (d & mask_of(off));
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model_rd(i);
        return f;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = v[7-i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        send_bits(v, 8);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = ~sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_m = 1'b1; wq();
            v[7-i] = sda_line; wq();
            scl_m = 1'b0;
        end
        wq();
        sda_m = ~give_ack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wr_byte(input int off, input logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(8'hD2, a1);
        send_byte({1'b1, 7'(off)}, a2);
        send_byte(d, a3);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic rd_byte(input int off, output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(8'hD2, a1);
        send_byte({1'b1, 7'(off)}, a2);
        bus_start();
        send_byte(8'hD3, a3);
        recv_byte(1'b0, d);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    // Block write of n bytes from xfer with a stated count; acks[i] per data byte
    task automatic blk_wr(input int cnt, input int nsend, output logic hdr_ok);
        logic a1, a2, a3, a;
        bus_start();
        send_byte(8'hD2, a1);
        send_byte(8'h00, a2);
        send_byte(8'(cnt), a3);
        for (int i = 0; i < nsend; i++) begin
            send_byte(xfer[i], a);
            acks[i] = a;
        end
        bus_stop();
        hdr_ok = a1 & a2 & a3;
    endtask

    task automatic blk_rd(input int len, output logic [7:0] cnt, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(8'hD2, a1);
        send_byte(8'h00, a2);
        bus_start();
        send_byte(8'hD3, a3);
        recv_byte(len > 0, cnt);
        for (int i = 0; i < len; i++) recv_byte(i < len - 1, xfer[i]);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic       ok, a;
        logic [7:0] d, cnt;
        int         seed;
        seed = $urandom(32'd5113);
        for (int i = 0; i < NREG; i++) exp_reg[i] = (i == 1) ? 8'h7F : 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 regs after reset", regs_flat, model_flat());
        check("R1 sda released", sda_oe, 1'b0);
        check("R1 cpu_oe reset", cpu_oe, 3'b111);
        check("R8 strap mirror at reset", regs_flat[7:0], 8'h02);

        // R10 control mapping
        wr_byte(1, 8'h05, ok); model_wr(1, 8'h05);
        check("R4 byte write acks", ok, 1'b1);
        wr_byte(2, 8'hA8, ok); model_wr(2, 8'hA8);
        check("R10 cpu_oe", cpu_oe, 3'b101);
        check("R10 src_oe/stop_en", {src_stop_en, src_oe}, 2'b00);
        check("R10 cpu_pd_tri", cpu_pd_tri, 3'b101);
        check("R10 src tri bits", {src_pd_tri, src_stop_tri}, 2'b10);
        check("R8 masked reg1/reg2", regs_flat[23:8], {8'hA8, 8'h3D});

        // R8 read-only register 0
        wr_byte(0, 8'hFF, ok);
        rd_byte(0, d, ok);
        check("R8 reg0 ignores write", d, 8'h02);
        strap = 2'b01;
        rd_byte(0, d, ok);
        check("R6 R8 reg0 follows strap", d, 8'h01);

        // R9 out-of-range offset
        wr_byte(9, 8'h55, ok);
        check("R9 write beyond end acked", ok, 1'b1);
        rd_byte(9, d, ok);
        check("R9 read beyond end", d, 8'h00);
        check("R9 no register touched", regs_flat, model_flat());

        // R4 second data byte in byte mode
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h83, a); send_byte(8'h11, a);
        check("R4 first data acked", a, 1'b1);
        send_byte(8'h22, a);
        bus_stop();
        model_wr(3, 8'h11);
        check("R4 extra data nacked", a, 1'b0);
        check("R4 extra data not stored", regs_flat, model_flat());

        // R5 block write with more bytes than counted
        xfer[0] = 8'hAA; xfer[1] = 8'h3C; xfer[2] = 8'hFF; xfer[3] = 8'h99;
        blk_wr(3, 4, ok);
        for (int i = 0; i < 3; i++) model_wr(i, xfer[i]);
        check("R5 header acked", ok, 1'b1);
        check("R5 data acks", acks[3:0], 4'b0111);
        check("R5 registers after block write", regs_flat, model_flat());

        // R3 illegal block command
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h05, a);
        check("R3 non-zero block command nacked", a, 1'b0);
        send_byte(8'h00, a);
        bus_stop();
        check("R3 following byte ignored", a, 1'b0);

        // R7 full block read
        blk_rd(NREG, cnt, ok);
        check("R7 block read addr acks", ok, 1'b1);
        check("R7 count byte", cnt, 8'(NREG));
        for (int i = 0; i < NREG; i++) check("R7 block read byte", xfer[i], model_rd(i));

        // R2 address mismatch
        bus_start();
        send_byte(8'hA4, a);
        check("R2 wrong address nacked", a, 1'b0);
        send_byte(8'h81, a); send_byte(8'h00, a);
        bus_stop();
        check("R2 later bytes nacked", a, 1'b0);
        check("R2 registers untouched", regs_flat, model_flat());

        // R11 stop in the middle of a block write
        xfer[0] = 8'h5A; xfer[1] = 8'h81;
        blk_wr(5, 2, ok);
        model_wr(0, 8'h5A); model_wr(1, 8'h81);
        check("R11 partial block kept", regs_flat, model_flat());

        // R11 start inside a command byte
        bus_start();
        send_byte(8'hD2, a);
        send_bits(8'h81, 3);
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h81, a); send_byte(8'h44, a);
        bus_stop();
        model_wr(1, 8'h44);
        check("R11 restart data acked", a, 1'b1);
        check("R11 restart write stored", regs_flat, model_flat());

        // R11 read with no command in this transaction
        bus_start();
        send_byte(8'hD3, a);
        bus_stop();
        check("R11 commandless read nacked", a, 1'b0);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int         kind;
            int         off;
            int         n;
            logic [7:0] v;
            kind = $urandom_range(0, 3);
            off  = $urandom_range(0, 9);
            v    = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 7) == 0) strap = 2'($urandom_range(0, 3));
            case (kind)
                0: begin
                    wr_byte(off, v, ok); model_wr(off, v);
                    check("R4 random byte write ack", ok, 1'b1);
                end
                1: begin
                    rd_byte(off, d, ok);
                    check("R6 random byte read", {ok, d}, {1'b1, model_rd(off)});
                end
                2: begin
                    n = $urandom_range(1, NREG);
                    for (int i = 0; i < n; i++) xfer[i] = 8'($urandom_range(0, 255));
                    blk_wr(n, n, ok);
                    for (int i = 0; i < n; i++) model_wr(i, xfer[i]);
                    check("R5 random block write acks", {ok, acks[NREG-1:0] & 7'((1 << n) - 1)},
                          {1'b1, 7'((1 << n) - 1)});
                end
                default: begin
                    n = $urandom_range(1, 9);
                    blk_rd(n, cnt, ok);
                    check("R7 random block count", {ok, cnt}, {1'b1, 8'(NREG)});
                    for (int i = 0; i < n; i++) check("R7 R9 random block byte", xfer[i], model_rd(i));
                end
            endcase
        end

        check("R1 R8 final register image", regs_flat, model_flat());
        check("R10 final cpu_oe", cpu_oe, exp_reg[1][2:0]);
        check("R10 final src bits", {src_stop_en, src_oe, src_pd_tri, src_stop_tri},
              {exp_reg[1][7:6], exp_reg[2][7:6]});
        check("R10 final cpu_pd_tri", cpu_pd_tri, exp_reg[2][5:3]);
        check("R12 sda moved while scl high", viol, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule